// File: doc/BRIEF.md
# Multi-Bank Open-Row Tracker

This block keeps a record of the DRAM rows that are currently open, one per slot, in a small set of slots (four by default). A command scheduler presents each access as a bank and row with a valid strobe. One clock later the block returns a class code that tells the scheduler what the access costs:

- a row hit, which needs no precharge or activate;
- a miss on an idle bank, which needs an activate only;
- a conflict with a different row in the same bank, which needs a precharge and then an activate;
- an eviction, where every slot is busy and the least recently used one must be precharged before the new bank is opened.

The returned slot index names the slot the access landed in. For a conflict or an eviction, that is the slot to precharge. The block treats every access it classifies as if the scheduler carries it out. It therefore updates its slot contents and its recency order at once. A refresh event closes every row. A precharge-done event closes the one slot that holds the named bank.

Top module: `row_tracker`

## Requirements
- R1: After reset no slot is open, `cls_valid` is low, and the recency order runs from slot 0 (least recent) up to slot NSLOT-1.
- R2: `cls_valid` is high in exactly the cycle after a cycle with `acc_valid` high, and low in every other cycle.
- R3: When the accessed bank is open with the same row, the class is 0 (hit) and `cls_slot` is that bank's slot.
- R4: When the accessed bank is not open and a slot is free, the class is 1 (idle miss). The lowest-numbered free slot is opened with the bank and row, and its index is returned.
- R5: When the accessed bank is open with a different row, the class is 2 (conflict). `cls_slot` is that bank's slot, and the slot now holds the new row.
- R6: When the accessed bank is not open and all slots are open, the class is 3 (eviction). The least recently used slot is returned and is reloaded with the new bank and row.
- R7: Every classified access makes its slot the most recently used. Slots that were more recent than it each move one step toward least recent.
- R8: A refresh closes all slots and restores the reset recency order.
- R9: A precharge-done event closes the slot that holds `pre_bank`. When no slot holds that bank, the event changes nothing.
- R10: When an access falls in the same cycle as a refresh or a precharge-done, the closures take effect first. The access is then classified against the state that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_bank | input | BANK_W | Bank of the access |
| acc_row | input | ROW_W | Row of the access |
| refresh | input | 1 | Refresh event: closes all rows |
| pre_done | input | 1 | Precharge of one bank has completed |
| pre_bank | input | BANK_W | Bank that was precharged |
| cls_valid | output | 1 | Class result valid |
| cls | output | 2 | 0 hit, 1 idle miss, 2 conflict, 3 eviction |
| cls_slot | output | SLOT_W | Slot hit, opened, or to be precharged |

## Verification
An access can fall in the same cycle as a closure event. Two cases are provoked. In the first, a precharge-done for an open bank is driven together with an access that would otherwise hit that bank's row. In the second, a refresh is driven together with an access while several slots are open. In both cases the result must be an idle miss into the lowest free slot, not a hit or an eviction. A follow-up access then confirms that the recency order left behind matches the closures applied first.

// File: rtl/row_tracker.sv
module row_tracker #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int NSLOT  = 4,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic              refresh,
  input  logic              pre_done,
  input  logic [BANK_W-1:0] pre_bank,
  output logic              cls_valid,
  output logic [1:0]        cls,
  output logic [SLOT_W-1:0] cls_slot
);
  localparam logic [1:0] C_HIT = 2'd0, C_IDLE = 2'd1, C_CONF = 2'd2, C_EVICT = 2'd3;
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(NSLOT - 1);

  logic [NSLOT-1:0]  vld;
  logic [BANK_W-1:0] bnk [NSLOT];
  logic [ROW_W-1:0]  rw  [NSLOT];
  logic [SLOT_W-1:0] age [NSLOT];

  logic [NSLOT-1:0]  v_eff;
  logic [SLOT_W-1:0] age_eff [NSLOT];
  logic              any_bank, any_free;
  logic [SLOT_W-1:0] bank_slot, free_slot, lru_slot, sel;
  logic [1:0]        code;

  always_comb begin
    any_bank  = 1'b0;
    any_free  = 1'b0;
    bank_slot = '0;
    free_slot = '0;
    lru_slot  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      v_eff[i]   = vld[i] & ~refresh & ~(pre_done && bnk[i] == pre_bank);
      age_eff[i] = refresh ? SLOT_W'(i) : age[i];
      if (v_eff[i] && bnk[i] == acc_bank) begin
        any_bank  = 1'b1;
        bank_slot = SLOT_W'(i);
      end
      if (!v_eff[i]) begin
        any_free  = 1'b1;
        free_slot = SLOT_W'(i);
      end
      if (age_eff[i] == '0) lru_slot = SLOT_W'(i);
    end
  end

  always_comb begin
    if (any_bank) begin
      sel  = bank_slot;
      code = (rw[bank_slot] == acc_row) ? C_HIT : C_CONF;
    end else if (any_free) begin
      sel  = free_slot;
      code = C_IDLE;
    end else begin
      sel  = lru_slot;
      code = C_EVICT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      cls_valid <= 1'b0;
      cls       <= C_HIT;
      cls_slot  <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        age[i] <= SLOT_W'(i);
        bnk[i] <= '0;
        rw[i]  <= '0;
      end
    end else begin
      cls_valid <= acc_valid;
      if (acc_valid) begin
        cls      <= code;
        cls_slot <= sel;
      end
      for (int i = 0; i < NSLOT; i++) begin
        if (acc_valid && SLOT_W'(i) == sel) begin
          vld[i] <= 1'b1;
          bnk[i] <= acc_bank;
          rw[i]  <= acc_row;
          age[i] <= TOP;
        end else begin
          vld[i] <= v_eff[i];
          if (acc_valid && age_eff[i] > age_eff[sel]) age[i] <= age_eff[i] - 1'b1;
          else age[i] <= age_eff[i];
        end
      end
    end
  end
endmodule

// File: rtl/row_tracker_chk.sv
module row_tracker_chk #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              refresh,
  input logic              pre_done,
  input logic              cls_valid,
  input logic [1:0]        cls,
  input logic [SLOT_W-1:0] cls_slot,
  input logic [NSLOT-1:0]  vld
);
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> cls_valid);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !cls_valid);
  p_slot_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> vld[cls_slot]);
  p_evict_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls == 2'd3) |-> (&vld));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !acc_valid) |=> (vld == '0));
  p_no_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh && !pre_done) |=> ($countones(vld) >= $countones($past(vld))));
  p_refresh_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && acc_valid) |=> (cls == 2'd1 && cls_slot == '0 && $countones(vld) == 1));
endmodule

bind row_tracker row_tracker_chk #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/test_row_tracker.sv
module test_row_tracker;
  localparam int BW = 3, RW = 14, NS = 4, SW = 2;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, refresh = 0, pre_done = 0;
  logic [BW-1:0] acc_bank = 0, pre_bank = 0;
  logic [RW-1:0] acc_row = 0;
  logic cls_valid;
  logic [1:0] cls;
  logic [SW-1:0] cls_slot;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  row_tracker #(.BANK_W(BW), .ROW_W(RW), .NSLOT(NS)) i_row_tracker (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic acc(int b, int r, int ec, int es, string req, bit rf = 0, bit pd = 0, int pb = 0);
    acc_valid = 1; acc_bank = BW'(b); acc_row = RW'(r);
    refresh = rf; pre_done = pd; pre_bank = BW'(pb);
    @(negedge clk);
    acc_valid = 0; refresh = 0; pre_done = 0;
    chk({req, " valid"}, int'(cls_valid), 1);
    chk({req, " class"}, int'(cls), ec);
    chk({req, " slot"}, int'(cls_slot), es);
  endtask

  task automatic evt(bit rf, bit pd, int pb);
    refresh = rf; pre_done = pd; pre_bank = BW'(pb);
    @(negedge clk);
    refresh = 0; pre_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 idle valid", int'(cls_valid), 0);
    acc(1, 16, 1, 0, "R1 first open slot0");
  endtask

  task automatic t_fill_hit;
    acc(2, 32, 1, 1, "R4 slot1");
    acc(3, 48, 1, 2, "R4 slot2");
    acc(4, 64, 1, 3, "R4 slot3");
    @(negedge clk);
    chk("R2 no strobe", int'(cls_valid), 0);
    acc(1, 16, 0, 0, "R3 hit");
  endtask

  task automatic t_evict_conf;
    acc(5, 80, 3, 1, "R6 evict lru");
    acc(3, 9, 2, 2, "R5 conflict");
    acc(3, 9, 0, 2, "R5 new row hit");
    acc(6, 96, 3, 3, "R7 mru order");
    acc(2, 32, 3, 0, "R7 next lru");
  endtask

  task automatic t_precharge;
    evt(0, 1, 5);
    acc(7, 112, 1, 1, "R9 freed slot");
    evt(0, 1, 0);
    acc(7, 112, 0, 1, "R9 unknown bank ignored");
  endtask

  task automatic t_same_cycle;
    acc(3, 9, 1, 2, "R10 precharge first", 0, 1, 3);
    acc(7, 112, 1, 0, "R10 refresh first", 1);
    acc(6, 96, 1, 1, "R8 all closed");
  endtask

  task automatic t_refresh_order;
    evt(1, 0, 0);
    acc(1, 1, 1, 0, "R8 open0");
    acc(2, 2, 1, 1, "R8 open1");
    acc(3, 3, 1, 2, "R8 open2");
    acc(4, 4, 1, 3, "R8 open3");
    acc(5, 5, 3, 0, "R8 order reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_evict_conf();
    t_precharge();
    t_same_cycle();
    t_refresh_order();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule